// File: doc/BRIEF.md
# Self-Checking Memory Scan with Reversed-Polynomial Signature

This block runs a read-only consistency scan over a bit-wide memory. A Galois linear feedback shift register walks the memory addresses, one address per clock, never reaching the all-zero value. A second shift register compresses the data bit returned for each address. Its feedback polynomial is the reciprocal of the address generator's, and the two registers start from fixed values. Because of this, the final signature is not an opaque hash: it equals the bitwise XOR of the bit-reversed addresses of every cell that held a 1. A single flipped cell therefore shows up directly as its own address, reversed.

A scan starts with a one-cycle `start` pulse. The memory returns the bit at `addr` within the same cycle on `rd_bit`. After the last address has been sampled, `done` pulses for one cycle and `sig` holds the result until the next scan. The scan length `DEPTH` may be shorter than the full period 2^ADDR_W − 1. In that case the seed is worked out at elaboration so that the walk still finishes on address 1, and the closed-form result still holds.

Top module: `recip_sig_tester`

## Requirements
- R1: After reset, `done` is 0, `sig` is all zeros and `addr` equals 1.
- R2: A `start` seen while idle makes, on the next cycle, `addr` equal to the seed and `sig` all zeros. With the defaults (ADDR_W=3, DEPTH=7) the seed is 2. For ADDR_W=4, POLY_LOW=4'b0011, DEPTH=11 the seed is 6.
- R3: During a scan, each new address is the previous one multiplied by X modulo the generator polynomial. That is: shift left by one, drop the bit that leaves, and XOR in POLY_LOW (the coefficients of X^0..X^(ADDR_W−1)) when that bit was 1. `addr` is never zero. At full depth the scan visits every nonzero address exactly once.
- R4: A scan samples exactly DEPTH addresses, and the last address sampled is 1.
- R5: The signature register stays all zeros while it reads 0 bits from the all-zero state. The first 1 read from that state sets it to the value with only the most significant bit set.
- R6: At the end of a scan, `sig` equals the XOR, over the sampled addresses whose bit was 1, of each address with its bit order reversed. For example, with ADDR_W=3 and only address 3 holding 1, `sig` is 6.
- R7: `done` is high for exactly the one cycle after the last sample. Afterwards `sig` and `addr` (which stays at 1) hold until the next accepted `start`.
- R8: A `start` pulse during a scan is ignored: the scan length, the address walk and the final `sig` are unchanged.
- R9: With DEPTH below 2^ADDR_W − 1, the scan visits DEPTH distinct nonzero addresses ending on 1, and R6 still holds over those addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan when idle |
| rd_bit | input | 1 | Memory data bit at `addr`, valid in the same cycle |
| addr | output | ADDR_W | Address currently being read |
| sig | output | ADDR_W | Signature register |
| done | output | 1 | One-cycle pulse at the end of a scan |

## Verification
The hardest case to reach is a memory image whose signature folds to zero or to the image of an unrelated single cell. There, only the exact XOR of reversed addresses tells a correct compressor from one with a wrong tap. The bench reaches it by sweeping all 128 images of the 3-bit configuration, which includes every cancelling combination. On the 11-deep configuration it drives every single-cell image and a set of random images. The bench also injects a `start` pulse in the middle of a scan.

// File: rtl/memsig_pkg.sv
package memsig_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  // Walks backwards from address 1 by (depth-1) inverse steps (multiply by X^-1).
  function automatic logic [31:0] seed_for(input int unsigned w,
                                           input logic [31:0] poly_low,
                                           input int unsigned depth);
    logic [31:0] a;
    logic [31:0] back_taps;
    logic        lsb;
    back_taps = (32'd1 << (w - 1)) | (poly_low >> 1);
    a = 32'd1;
    for (int unsigned i = 1; i < depth; i++) begin
      lsb = a[0];
      a   = a >> 1;
      if (lsb) a = a ^ back_taps;
    end
    return a;
  endfunction

  // Low coefficients of the reciprocal polynomial X^w * p(1/X).
  function automatic logic [31:0] reciprocal_low(input int unsigned w,
                                                 input logic [31:0] poly_low);
    logic [31:0] r;
    r = 32'd1;
    for (int unsigned i = 1; i < w; i++) begin
      r[i] = poly_low[w - i];
    end
    return r;
  endfunction

endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import memsig_pkg::*;
#(
  parameter int unsigned DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic done
);

  localparam int unsigned CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

  run_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    last    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        step = 1'b1;
        if (cnt_q == CNT_LAST) begin
          last    = 1'b1;
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;

  // R7: completion flag lasts one cycle only
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: a running scan keeps counting regardless of start
  p_run_advances_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q != CNT_LAST) |=>
      (state_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));

  // R4: the final sample returns the sequencer to idle with done raised
  p_end_of_scan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q == CNT_LAST) |=> (state_q == ST_IDLE && done_q));

endmodule

// File: rtl/galois_addr_gen.sv
module galois_addr_gen #(
  parameter int unsigned        ADDR_W   = 3,
  parameter logic [ADDR_W-1:0]  POLY_LOW = 3'b011,
  parameter logic [ADDR_W-1:0]  SEED     = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              last,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] times_x;
  logic              advance;

  always_comb begin
    times_x = addr_q << 1;
    if (addr_q[ADDR_W-1]) times_x = times_x ^ POLY_LOW;
  end

  assign advance = step && !last;

  always_comb begin
    addr_d = addr_q;
    if (load)         addr_d = SEED;
    else if (advance) addr_d = times_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= ADDR_ONE;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R3: the walk never lands on the zero address
  p_addr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q != '0);

  // R4: the final sampled address is 1
  p_last_is_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> addr_q == ADDR_ONE);

  // R2: an accepted start loads the seed
  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr_q == SEED);

  // R7: address holds while idle
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr_q));

endmodule

// File: rtl/recip_sig_reg.sv
module recip_sig_reg #(
  parameter int unsigned       ADDR_W     = 3,
  parameter logic [ADDR_W-1:0] RECIP_LOW  = 3'b101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              data_in,
  output logic [ADDR_W-1:0] sig
);

  localparam logic [ADDR_W-1:0] INJECT = ADDR_W'(1) << (ADDR_W - 1);

  logic [ADDR_W-1:0] sig_q, sig_d;
  logic [ADDR_W-1:0] shifted;

  always_comb begin
    shifted = sig_q << 1;
    if (sig_q[ADDR_W-1]) shifted = shifted ^ RECIP_LOW;
    if (data_in)         shifted = shifted ^ INJECT;
  end

  always_comb begin
    sig_d = sig_q;
    if (clear)     sig_d = '0;
    else if (step) sig_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_d;
  end

  assign sig = sig_q;

  // R5: zeros read from the cleared state leave it cleared
  p_zero_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && sig_q == '0 && !data_in) |=> sig_q == '0);

  // R5: first one from the cleared state sets only the top bit
  p_first_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && sig_q == '0 && data_in) |=> sig_q == INJECT);

  // R2: start clears the signature
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> sig_q == '0);

  // R7: signature holds between scans
  p_sig_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(sig_q));

endmodule

// File: rtl/recip_sig_tester.sv
module recip_sig_tester
  import memsig_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] POLY_LOW = 3'b011,
  parameter int unsigned       DEPTH    = (2 ** ADDR_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_bit,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] sig,
  output logic              done
);

  localparam logic [31:0]       SEED_FULL  = seed_for(ADDR_W, 32'(POLY_LOW), DEPTH);
  localparam logic [ADDR_W-1:0] SEED       = SEED_FULL[ADDR_W-1:0];
  localparam logic [31:0]       RECIP_FULL = reciprocal_low(ADDR_W, 32'(POLY_LOW));
  localparam logic [ADDR_W-1:0] RECIP_LOW  = RECIP_FULL[ADDR_W-1:0];

  logic rst_meta_q, rst_sync_q;
  logic load, step, last;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  scan_sequencer #(
    .DEPTH (DEPTH)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .done  (done)
  );

  galois_addr_gen #(
    .ADDR_W   (ADDR_W),
    .POLY_LOW (POLY_LOW),
    .SEED     (SEED)
  ) u_gen (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .load  (load),
    .step  (step),
    .last  (last),
    .addr  (addr)
  );

  recip_sig_reg #(
    .ADDR_W    (ADDR_W),
    .RECIP_LOW (RECIP_LOW)
  ) u_sig (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .clear   (load),
    .step    (step),
    .data_in (rd_bit),
    .sig     (sig)
  );

  // R1: idle outputs right after reset release
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(rst_sync_q) |-> (!done && sig == '0));

endmodule

// File: tb/sim_recip_sig_tester.sv
module sim_recip_sig_tester;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start0 = 1'b0, start1 = 1'b0;
  logic [7:0]  mem0 = '0;
  logic [15:0] mem1 = '0;
  logic [2:0]  addr0, sig0;
  logic [3:0]  addr1, sig1;
  logic        done0, done1;
  logic        rd0, rd1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign rd0 = mem0[addr0];
  assign rd1 = mem1[addr1];

  recip_sig_tester #(.ADDR_W(3), .POLY_LOW(3'b011), .DEPTH(7)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start0), .rd_bit(rd0),
    .addr(addr0), .sig(sig0), .done(done0));

  recip_sig_tester #(.ADDR_W(4), .POLY_LOW(4'b0011), .DEPTH(11)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .rd_bit(rd1),
    .addr(addr1), .sig(sig1), .done(done1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mulx(input int a, input int w, input int poly);
    int r;
    r = (a << 1) & ((1 << w) - 1);
    if ((a >> (w - 1)) & 1) r = r ^ poly;
    return r;
  endfunction

  function automatic int rev(input int a, input int w);
    int r = 0;
    for (int i = 0; i < w; i++) if ((a >> i) & 1) r |= 1 << (w - 1 - i);
    return r;
  endfunction

  function automatic int cur_addr(input int which);
    return (which == 0) ? int'(addr0) : int'(addr1);
  endfunction
  function automatic int cur_sig(input int which);
    return (which == 0) ? int'(sig0) : int'(sig1);
  endfunction
  function automatic bit cur_done(input int which);
    return (which == 0) ? done0 : done1;
  endfunction

  task automatic set_start(input int which, input logic v);
    if (which == 0) start0 = v; else start1 = v;
  endtask

  task automatic run(input int which, input int pattern, input bit glitch);
    int w     = (which == 0) ? 3 : 4;
    int depth = (which == 0) ? 7 : 11;
    int poly  = (which == 0) ? 3 : 3;
    int seed  = (which == 0) ? 2 : 6;
    int seen  = 0;
    int prev  = 0;
    int exp_sig = 0;
    int a;
    bit any_one = 1'b0;
    int held_sig;
    if (which == 0) mem0 = 8'(pattern); else mem1 = 16'(pattern);
    @(negedge clk); set_start(which, 1'b1);
    @(negedge clk); set_start(which, 1'b0);
    for (int j = 0; j < depth; j++) begin
      a = cur_addr(which);
      if (j == 0) chk(a == seed, "R2 seed address", a, seed);
      if (j == 0) chk(cur_sig(which) == 0, "R2 cleared signature", cur_sig(which), 0);
      chk(a != 0, "R3 nonzero address", a, 1);
      chk(((seen >> a) & 1) == 0, "R9 distinct address", a, -1);
      if (j > 0) chk(a == mulx(prev, w, poly), "R3 multiply by X", a, mulx(prev, w, poly));
      if (!any_one) chk(cur_sig(which) == 0, "R5 zero stays zero", cur_sig(which), 0);
      chk(!cur_done(which), "R7 done low during scan", cur_done(which), 0);
      seen |= 1 << a;
      if ((pattern >> a) & 1) begin
        exp_sig ^= rev(a, w);
        any_one = 1'b1;
      end
      prev = a;
      if (glitch && j == 3) set_start(which, 1'b1);
      if (glitch && j == 4) set_start(which, 1'b0);
      @(negedge clk);
      if (j == 0 && ((pattern >> a) & 1))
        chk(cur_sig(which) == (1 << (w - 1)), "R5 first one sets top bit",
            cur_sig(which), 1 << (w - 1));
    end
    set_start(which, 1'b0);
    chk(prev == 1, "R4 last sampled address is 1", prev, 1);
    chk(cur_done(which), "R7 done after last sample", cur_done(which), 1);
    chk(cur_sig(which) == exp_sig, glitch ? "R8 signature with mid-scan start" : "R6 final signature",
        cur_sig(which), exp_sig);
    if (which == 0 && depth == 7)
      chk(seen == 8'hFE, "R3 full address coverage", seen, 8'hFE);
    held_sig = cur_sig(which);
    @(negedge clk);
    chk(!cur_done(which), "R7 done is one cycle", cur_done(which), 0);
    @(negedge clk);
    chk(cur_sig(which) == held_sig, "R7 signature holds", cur_sig(which), held_sig);
    chk(cur_addr(which) == 1, "R7 address holds", cur_addr(which), 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done0 && !done1, "R1 done after reset", int'(done0 | done1), 0);
    chk(sig0 == 0 && sig1 == 0, "R1 signature after reset", int'(sig0) + int'(sig1), 0);
    chk(addr0 == 1 && addr1 == 1, "R1 address after reset", int'(addr0) + int'(addr1), 2);

    // R6 worked example: only address 3 holds 1
    run(0, 32'h8, 1'b0);
    chk(sig0 == 3'd6, "R6 single cell 3 gives 6", int'(sig0), 6);

    // R6 exhaustive sweep of every 7-cell image
    for (int p = 0; p < 128; p++) run(0, p << 1, 1'b0);

    // R8 start pulse inside a scan
    run(0, 8'b1011_0110, 1'b1);
    run(1, 16'h5A3C, 1'b1);

    // R9 shortened depth: every single-cell image then random images
    for (int c = 1; c < 16; c++) run(1, 1 << c, 1'b0);
    for (int r = 0; r < 40; r++) run(1, int'($urandom & 32'hFFFE), 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule